// File: doc/BRIEF.md
# Multi-Way Sequential Stream Buffer

This block is a prefetch engine placed beside a cache. It receives the line addresses of demand misses. It keeps several independent stream buffers, and each buffer runs ahead of one sequential stream of cache lines. Every buffer holds the next DEPTH line addresses after the line most recently demanded from it. A demand is compared with every entry of every buffer in the same cycle.

When a demand matches a buffered line, the block returns that line's data on the hit port. The buffer then advances past the matched entry, even if entries before it were skipped, and queues the lines that become newly visible. When a demand matches no buffer, the least-recently-used buffer is flushed and restarted behind the demand, and the demand itself is forwarded to memory. Prefetch requests use the same memory request port but only go out when no demand is waiting on it. Fills return on a separate response port and are matched by line address.

The controller has three states:
- `S_IDLE` accepts demands. If the demand matches a ready entry it stays in `S_IDLE` (the hit transition). If the demand matches an entry that is queued or in flight it moves to `S_WAIT` (the wait transition). If the demand matches nothing it moves to `S_MISS` (the allocate transition).
- `S_WAIT` returns to `S_IDLE` once the awaited entry holds data.
- `S_MISS` returns to `S_IDLE` once memory accepts the demand request.

Top module: `strm_prefetch`

## Requirements
- R1: After reset, `dmd_ready` is 1, `mreq_valid` is 0 and `hit_valid` is 0, and every buffer is empty.
- R2: A demand for line X that matches no buffer causes the following:
  - The least-recently-used buffer is flushed. After reset, buffer NUM_BUF-1 is the first victim, then NUM_BUF-2, and so on.
  - That buffer queues lines X+1 to X+DEPTH.
  - From the next cycle, `mreq_valid`=1 with `mreq_demand`=1 and `mreq_line`=X, held until `mreq_ready`.
- R3: A demand request always has priority over prefetch requests. When no demand request is waiting, one queued entry is requested per cycle (`mreq_demand`=0). The lowest buffer index wins, then the lowest slot, where slot 0 is the line right after the last demanded one. A request is consumed when `mreq_ready` is 1.
- R4: A demand that matches an entry which already holds data is accepted in one cycle. In the next cycle, `hit_valid` is 1 for one cycle, with `hit_line` equal to the demand line and `hit_data` equal to the data filled for that line.
- R5: A hit on slot k advances that buffer by k+1 entries. The following lines are queued at the tail, in order.
- R6: A demand that matches an entry which is queued or awaiting its fill issues no new request for that line. The block reports the hit in the cycle after the fill is stored.
- R7: An entry is only queued if its line lies in the same 4 KiB page as the buffer's last demanded line. With 64-byte lines, the page is line bits [LAW-1:6]. Lines outside that page are never requested.
- R8: A fill updates every in-flight entry whose line equals `fill_line`. A fill that matches no in-flight entry changes nothing.
- R9: Interleaved streams, such as A, B, A+1, B+1, are each kept in their own buffer, and each is served by hits.
- R10: `dmd_ready` is 0 while the block waits for a fill or for memory to accept a demand request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmd_valid | input | 1 | Demand miss present |
| dmd_ready | output | 1 | Block can accept a demand |
| dmd_line | input | LAW | Demand line address |
| hit_valid | output | 1 | One-cycle hit indication |
| hit_line | output | LAW | Line of the hit |
| hit_data | output | DW | Data of the hit line |
| mreq_valid | output | 1 | Memory line request valid |
| mreq_ready | input | 1 | Memory accepts the request |
| mreq_line | output | LAW | Requested line address |
| mreq_demand | output | 1 | 1 for a forwarded demand, 0 for a prefetch |
| fill_valid | input | 1 | Fill response present |
| fill_line | input | LAW | Line of the fill |
| fill_data | input | DW | Fill data |

## Verification
The assertions check, on every cycle, the properties that need only the port timing:
- A stalled demand request keeps its line and stays in front of prefetches.
- The demand port is closed while a demand request is out.
- A hit is only reported with the controller back in `S_IDLE`.
- A demand request always comes from the demand accepted one cycle earlier.

Some behaviours can only be shown by the bench's scenarios against its reference model:
- the skip distance of an advance;
- the choice of the least-recently-used victim;
- page-limited queuing;
- waiting on an in-flight entry;
- ignoring stray fills;
- keeping interleaved streams apart.

// File: rtl/strm_pkg.sv
package strm_pkg;
    typedef enum logic [1:0] {E_EMPTY, E_QUEUED, E_PEND, E_READY} ent_st_t;
    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_MISS} fsm_t;
endpackage

// File: rtl/strm_pick.sv
module strm_pick #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest set bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/strm_lru.sv
module strm_lru #(
    parameter int NB = 4,
    parameter int BW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [BW-1:0] touch_idx,
    output logic [BW-1:0] victim
);
    // rank 0 = most recent, NB-1 = least recent
    logic [BW-1:0] rank_q [NB];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) rank_q[b] <= BW'(b);
        end else if (touch_en) begin
            for (int b = 0; b < NB; b++) begin
                if (int'(touch_idx) == b)
                    rank_q[b] <= '0;
                else if (rank_q[b] < rank_q[touch_idx])
                    rank_q[b] <= rank_q[b] + 1'b1;
            end
        end
    end

    always_comb begin
        victim = '0;
        for (int b = 0; b < NB; b++)
            if (rank_q[b] == BW'(NB - 1)) victim = BW'(b);
    end
endmodule

// File: rtl/strm_lane.sv
module strm_lane
    import strm_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LAW   = 20,
    parameter int DW    = 32,
    parameter int PGB   = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LAW-1:0]                look_line,
    input  logic                          fill_valid,
    input  logic [LAW-1:0]                fill_line,
    input  logic [DW-1:0]                 fill_data,
    input  logic                          iss_en,
    input  logic [$clog2(DEPTH)-1:0]      iss_slot,
    input  logic                          alloc_en,
    input  logic [LAW-1:0]                alloc_line,
    input  logic                          adv_en,
    input  logic [$clog2(DEPTH+1)-1:0]    adv_cnt,
    output logic [DEPTH-1:0]              match_o,
    output logic [DEPTH-1:0]              ready_o,
    output logic [DEPTH-1:0]              queued_o,
    output logic [LAW-1:0]                head_o,
    output logic [DEPTH-1:0][DW-1:0]      data_o
);
    ent_st_t        st_q  [DEPTH];
    ent_st_t        st_p  [DEPTH];
    ent_st_t        st_n  [DEPTH];
    logic [DW-1:0]  dat_q [DEPTH];
    logic [DW-1:0]  dat_p [DEPTH];
    logic [DW-1:0]  dat_n [DEPTH];
    logic [LAW-1:0] head_q, head_n;

    always_comb begin
        logic [LAW-1:0] a;
        a = '0;
        // fills and issue act on the current window
        for (int k = 0; k < DEPTH; k++) begin
            st_p[k]  = st_q[k];
            dat_p[k] = dat_q[k];
            if (fill_valid && st_q[k] == E_PEND && (head_q + LAW'(k)) == fill_line) begin
                st_p[k]  = E_READY;
                dat_p[k] = fill_data;
            end
            if (iss_en && int'(iss_slot) == k) st_p[k] = E_PEND;
        end
        head_n = head_q;
        for (int k = 0; k < DEPTH; k++) begin
            st_n[k]  = st_p[k];
            dat_n[k] = dat_p[k];
        end
        if (alloc_en) begin
            head_n = alloc_line + 1'b1;
            for (int k = 0; k < DEPTH; k++) begin
                a        = alloc_line + LAW'(k + 1);
                st_n[k]  = (a[LAW-1:PGB] == alloc_line[LAW-1:PGB]) ? E_QUEUED : E_EMPTY;
                dat_n[k] = '0;
            end
        end else if (adv_en) begin
            head_n = head_q + LAW'(adv_cnt);
            for (int k = 0; k < DEPTH; k++) begin
                if (k + int'(adv_cnt) < DEPTH) begin
                    st_n[k]  = st_p[k + int'(adv_cnt)];
                    dat_n[k] = dat_p[k + int'(adv_cnt)];
                end else begin
                    a        = head_n + LAW'(k);
                    st_n[k]  = (a[LAW-1:PGB] == (head_n - 1'b1) >> PGB) ? E_QUEUED : E_EMPTY;
                    dat_n[k] = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            for (int k = 0; k < DEPTH; k++) begin
                st_q[k]  <= E_EMPTY;
                dat_q[k] <= '0;
            end
        end else begin
            head_q <= head_n;
            for (int k = 0; k < DEPTH; k++) begin
                st_q[k]  <= st_n[k];
                dat_q[k] <= dat_n[k];
            end
        end
    end

    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            match_o[k]  = (st_q[k] != E_EMPTY) && ((head_q + LAW'(k)) == look_line);
            ready_o[k]  = (st_q[k] == E_READY);
            queued_o[k] = (st_q[k] == E_QUEUED);
            data_o[k]   = dat_q[k];
        end
    end
    assign head_o = head_q;
endmodule

// File: rtl/strm_prefetch.sv
module strm_prefetch
    import strm_pkg::*;
#(
    parameter int NUM_BUF    = 4,
    parameter int DEPTH      = 4,
    parameter int LAW        = 20,
    parameter int DW         = 32,
    parameter int PAGE_BYTES = 4096,
    parameter int LINE_BYTES = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dmd_valid,
    output logic           dmd_ready,
    input  logic [LAW-1:0] dmd_line,
    output logic           hit_valid,
    output logic [LAW-1:0] hit_line,
    output logic [DW-1:0]  hit_data,
    output logic           mreq_valid,
    input  logic           mreq_ready,
    output logic [LAW-1:0] mreq_line,
    output logic           mreq_demand,
    input  logic           fill_valid,
    input  logic [LAW-1:0] fill_line,
    input  logic [DW-1:0]  fill_data
);
    localparam int PGB = $clog2(PAGE_BYTES / LINE_BYTES);
    localparam int NE  = NUM_BUF * DEPTH;
    localparam int EW  = $clog2(NE);
    localparam int BW  = $clog2(NUM_BUF);
    localparam int SW  = $clog2(DEPTH);
    localparam int CW  = $clog2(DEPTH + 1);

    fsm_t           st_q, st_d;
    logic [LAW-1:0] cur_q, cur_d;
    logic [BW-1:0]  wb_q, wb_d;
    logic [SW-1:0]  wk_q, wk_d;
    logic           hit_q, hit_d;
    logic [LAW-1:0] hline_q, hline_d;
    logic [DW-1:0]  hdata_q, hdata_d;

    logic [NUM_BUF-1:0][DEPTH-1:0]         match_all, ready_all, queued_all;
    logic [NUM_BUF-1:0][LAW-1:0]           head_all;
    logic [NUM_BUF-1:0][DEPTH-1:0][DW-1:0] data_all;
    logic [NE-1:0]                         flat_match, flat_q;
    logic [NUM_BUF-1:0]                    iss_en, adv_en, alloc_en;
    logic [CW-1:0]                         adv_cnt;
    logic                                  m_found, q_found, touch_en;
    logic [EW-1:0]                         m_idx, q_idx;
    logic [BW-1:0]                         m_b, q_b, victim, touch_idx;
    logic [SW-1:0]                         m_k, q_k;

    for (genvar b = 0; b < NUM_BUF; b++) begin : g_lane
        strm_lane #(.DEPTH(DEPTH), .LAW(LAW), .DW(DW), .PGB(PGB)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .look_line  (dmd_line),
            .fill_valid (fill_valid),
            .fill_line  (fill_line),
            .fill_data  (fill_data),
            .iss_en     (iss_en[b]),
            .iss_slot   (q_k),
            .alloc_en   (alloc_en[b]),
            .alloc_line (dmd_line),
            .adv_en     (adv_en[b]),
            .adv_cnt    (adv_cnt),
            .match_o    (match_all[b]),
            .ready_o    (ready_all[b]),
            .queued_o   (queued_all[b]),
            .head_o     (head_all[b]),
            .data_o     (data_all[b])
        );
        assign flat_match[b*DEPTH +: DEPTH] = match_all[b];
        assign flat_q[b*DEPTH +: DEPTH]     = queued_all[b];
        assign iss_en[b] = (st_q != S_MISS) && q_found && mreq_ready && (int'(q_b) == b);
    end

    strm_pick #(.N(NE)) u_pick_match (.vec(flat_match), .found(m_found), .idx(m_idx));
    strm_pick #(.N(NE)) u_pick_queue (.vec(flat_q),     .found(q_found), .idx(q_idx));

    strm_lru #(.NB(NUM_BUF)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_idx(touch_idx), .victim(victim)
    );

    assign m_b = BW'(int'(m_idx) / DEPTH);
    assign m_k = SW'(int'(m_idx) % DEPTH);
    assign q_b = BW'(int'(q_idx) / DEPTH);
    assign q_k = SW'(int'(q_idx) % DEPTH);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            cur_q   <= '0;
            wb_q    <= '0;
            wk_q    <= '0;
            hit_q   <= 1'b0;
            hline_q <= '0;
            hdata_q <= '0;
        end else begin
            st_q    <= st_d;
            cur_q   <= cur_d;
            wb_q    <= wb_d;
            wk_q    <= wk_d;
            hit_q   <= hit_d;
            hline_q <= hline_d;
            hdata_q <= hdata_d;
        end
    end

    // next state and lane controls
    always_comb begin
        st_d      = st_q;
        cur_d     = cur_q;
        wb_d      = wb_q;
        wk_d      = wk_q;
        hit_d     = 1'b0;
        hline_d   = hline_q;
        hdata_d   = hdata_q;
        adv_en    = '0;
        alloc_en  = '0;
        adv_cnt   = '0;
        touch_en  = 1'b0;
        touch_idx = '0;
        unique case (st_q)
            S_IDLE: begin
                if (dmd_valid) begin
                    cur_d = dmd_line;
                    if (m_found) begin
                        if (ready_all[m_b][m_k]) begin
                            hit_d       = 1'b1;
                            hline_d     = dmd_line;
                            hdata_d     = data_all[m_b][m_k];
                            adv_en[m_b] = 1'b1;
                            adv_cnt     = CW'(m_k) + CW'(1);
                            touch_en    = 1'b1;
                            touch_idx   = m_b;
                        end else begin
                            st_d = S_WAIT;
                            wb_d = m_b;
                            wk_d = m_k;
                        end
                    end else begin
                        alloc_en[victim] = 1'b1;
                        touch_en         = 1'b1;
                        touch_idx        = victim;
                        st_d             = S_MISS;
                    end
                end
            end
            S_WAIT: begin
                if (ready_all[wb_q][wk_q]) begin
                    hit_d        = 1'b1;
                    hline_d      = cur_q;
                    hdata_d      = data_all[wb_q][wk_q];
                    adv_en[wb_q] = 1'b1;
                    adv_cnt      = CW'(wk_q) + CW'(1);
                    touch_en     = 1'b1;
                    touch_idx    = wb_q;
                    st_d         = S_IDLE;
                end
            end
            S_MISS: begin
                if (mreq_ready) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    // outputs
    assign dmd_ready   = (st_q == S_IDLE);
    assign mreq_valid  = (st_q == S_MISS) || q_found;
    assign mreq_demand = (st_q == S_MISS);
    assign mreq_line   = (st_q == S_MISS) ? cur_q : head_all[q_b] + LAW'(q_k);
    assign hit_valid   = hit_q;
    assign hit_line    = hline_q;
    assign hit_data    = hdata_q;
endmodule

// File: rtl/strm_prefetch_chk.sv
module strm_prefetch_chk #(
    parameter int LAW = 20
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dmd_valid,
    input logic           dmd_ready,
    input logic [LAW-1:0] dmd_line,
    input logic           hit_valid,
    input logic           mreq_valid,
    input logic           mreq_ready,
    input logic           mreq_demand,
    input logic [LAW-1:0] mreq_line
);
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!mreq_valid && !hit_valid && dmd_ready)); // R1

    AST_MISS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mreq_valid && mreq_demand) |-> ($past(dmd_valid && dmd_ready) && mreq_line == $past(dmd_line))); // R2

    AST_DMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && mreq_demand && !mreq_ready) |=> (mreq_valid && mreq_demand && $stable(mreq_line))); // R3

    AST_HIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> dmd_ready); // R4

    AST_DMD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && mreq_demand) |-> !dmd_ready); // R10
endmodule

bind strm_prefetch strm_prefetch_chk #(.LAW(LAW)) u_chk (
    .clk(clk), .rst_n(rst_n), .dmd_valid(dmd_valid), .dmd_ready(dmd_ready),
    .dmd_line(dmd_line), .hit_valid(hit_valid), .mreq_valid(mreq_valid),
    .mreq_ready(mreq_ready), .mreq_demand(mreq_demand), .mreq_line(mreq_line)
);

// File: tb/strm_prefetch_bench.sv
`timescale 1ns/1ps
module strm_prefetch_bench;
    localparam int NB = 4, D = 4, LAW = 20, DW = 32, LAT = 3, ND = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dmd_valid = 1'b0, mreq_ready = 1'b0, fill_valid = 1'b0;
    logic [LAW-1:0] dmd_line = '0, fill_line = '0;
    logic [DW-1:0]  fill_data = '0;
    logic dmd_ready, hit_valid, mreq_valid, mreq_demand;
    logic [LAW-1:0] hit_line, mreq_line;
    logic [DW-1:0]  hit_data;

    always #10 clk = ~clk;

    strm_prefetch u_strm_prefetch (.*);

    int checks = 0, errors = 0;
    // reference model state: 0 empty, 1 queued, 2 in flight, 3 holds data
    int m_st [NB][D];
    logic [31:0] m_dat [NB][D];
    int m_head [NB], m_rank [NB];
    int m_fsm, m_wb, m_wk, m_cur, m_hitv, m_hitl;
    logic [31:0] m_hitd;
    int mf, mb, mk, qf, qb, qk, rv, rd, rl;
    int q_due [$], q_line [$];
    int dtime [ND], dlist [ND];
    int cross_cnt = 0, saw_6000 = 0, dut_hits = 0, mdl_hits = 0;

    function automatic logic [31:0] fdat(int line);
        return 32'(line) * 32'd13 + 32'd5;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_comb();
        mf = 0; qf = 0; mb = 0; mk = 0; qb = 0; qk = 0;
        for (int b = NB - 1; b >= 0; b--)
            for (int k = D - 1; k >= 0; k--) begin
                if (m_st[b][k] != 0 && m_head[b] + k == int'(dmd_line)) begin mf = 1; mb = b; mk = k; end
                if (m_st[b][k] == 1) begin qf = 1; qb = b; qk = k; end
            end
        rv = (m_fsm == 2 || qf == 1) ? 1 : 0;
        rd = (m_fsm == 2) ? 1 : 0;
        rl = (m_fsm == 2) ? m_cur : m_head[qb] + qk;
    endtask

    task automatic touch(int t);
        int r = m_rank[t];
        for (int b = 0; b < NB; b++)
            if (b == t) m_rank[b] = 0;
            else if (m_rank[b] < r) m_rank[b]++;
    endtask

    function automatic int page_of(int line);
        return line >> 6;
    endfunction

    task automatic model_step(input logic rdy);
        int pst [NB][D];
        logic [31:0] pd [NB][D];
        int sb, ss;
        sb = -1; ss = 0;
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < D; k++) begin
                pst[b][k] = m_st[b][k]; pd[b][k] = m_dat[b][k];
                if (fill_valid && m_st[b][k] == 2 && m_head[b] + k == int'(fill_line)) begin
                    pst[b][k] = 3; pd[b][k] = fill_data;
                end
            end
        if (m_fsm != 2 && qf == 1 && rdy) pst[qb][qk] = 2;
        m_hitv = 0;
        if (m_fsm == 0) begin
            if (dmd_valid) begin
                m_cur = int'(dmd_line);
                if (mf == 1) begin
                    if (m_st[mb][mk] == 3) begin
                        m_hitv = 1; m_hitl = m_cur; m_hitd = m_dat[mb][mk];
                        sb = mb; ss = mk + 1; touch(mb);
                    end else begin
                        m_fsm = 1; m_wb = mb; m_wk = mk;
                    end
                end else begin
                    int v = 0;
                    for (int b = 0; b < NB; b++) if (m_rank[b] == NB - 1) v = b;
                    m_head[v] = m_cur + 1;
                    for (int k = 0; k < D; k++) begin
                        pst[v][k] = (page_of(m_cur + 1 + k) == page_of(m_cur)) ? 1 : 0;
                        pd[v][k] = '0;
                    end
                    touch(v); m_fsm = 2;
                end
            end
        end else if (m_fsm == 1) begin
            if (m_st[m_wb][m_wk] == 3) begin
                m_hitv = 1; m_hitl = m_cur; m_hitd = m_dat[m_wb][m_wk];
                sb = m_wb; ss = m_wk + 1; touch(m_wb); m_fsm = 0;
            end
        end else if (rdy) m_fsm = 0;
        if (sb >= 0) begin
            int tst [D];
            logic [31:0] td [D];
            int nh = m_head[sb] + ss;
            for (int k = 0; k < D; k++) begin
                if (k + ss < D) begin tst[k] = pst[sb][k + ss]; td[k] = pd[sb][k + ss]; end
                else begin
                    tst[k] = (page_of(nh + k) == page_of(nh - 1)) ? 1 : 0; td[k] = '0;
                end
            end
            for (int k = 0; k < D; k++) begin pst[sb][k] = tst[k]; pd[sb][k] = td[k]; end
            m_head[sb] = nh;
        end
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < D; k++) begin m_st[b][k] = pst[b][k]; m_dat[b][k] = pd[b][k]; end
        mdl_hits += m_hitv;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        int di, acc;
        logic rdy;
        dtime = '{5, 6, 30, 31, 45, 46, 60, 61, 62, 90, 91, 92, 93, 140, 141, 150, 205, 206, 260, 261, 262};
        dlist = '{'h1000, 'h2038, 'h1001, 'h2039, 'h1003, 'h203B, 'h203D, 'h1005, 'h1006,
                  'h3000, 'h4000, 'h5000, 'h5001, 'h203E, 'h203F, 'h3002, 'h6000, 'h6001,
                  'h4004, 'h7000, 'h1000};
        for (int b = 0; b < NB; b++) begin
            m_head[b] = 0; m_rank[b] = b;
            for (int k = 0; k < D; k++) begin m_st[b][k] = 0; m_dat[b][k] = '0; end
        end
        m_fsm = 0; m_wb = 0; m_wk = 0; m_cur = 0; m_hitv = 0; m_hitl = 0; m_hitd = '0;
        di = 0; acc = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset dmd_ready", dmd_ready, 1);
        check("R1 reset mreq_valid", mreq_valid, 0);
        check("R1 reset hit_valid", hit_valid, 0);
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (acc == 1) begin dmd_valid = 1'b0; di++; acc = 0; end
            if (q_due.size() > 0 && q_due[0] == cyc) begin
                fill_valid = 1'b1; fill_line = LAW'(q_line[0]); fill_data = fdat(q_line[0]);
                void'(q_due.pop_front()); void'(q_line.pop_front());
            end else if (cyc == 120) begin
                // stray fill for a line no entry waits for (R8)
                fill_valid = 1'b1; fill_line = LAW'('h7F000); fill_data = 32'hDEAD0000;
            end else begin
                fill_valid = 1'b0;
            end
            rdy = !(cyc >= 200 && cyc < 230) && (cyc % 5 != 4);
            mreq_ready = rdy;
            if (!dmd_valid && di < ND && m_fsm == 0 && cyc >= dtime[di]) begin
                dmd_valid = 1'b1; dmd_line = LAW'(dlist[di]);
            end
            #1;
            model_comb();
            check("R10 dmd_ready", dmd_ready, (m_fsm == 0) ? 1 : 0);
            check("R2 R3 R7 R9 mreq_valid", mreq_valid, rv);
            if (rv == 1) begin
                check("R2 R3 mreq_demand", mreq_demand, rd);
                check("R3 R5 R7 R9 mreq_line", mreq_line, rl);
            end
            check("R4 R5 R6 R8 hit_valid", hit_valid, m_hitv);
            if (m_hitv == 1) begin
                check("R4 R9 hit_line", hit_line, m_hitl);
                check("R4 R8 hit_data", hit_data, m_hitd);
            end
            dut_hits += int'(hit_valid);
            if (mreq_valid && mreq_ready) begin
                if (!mreq_demand && (mreq_line == LAW'('h2040) || mreq_line == LAW'('h2041))) cross_cnt++;
                if (mreq_demand && mreq_line == LAW'('h6000)) saw_6000 = 1;
            end
            if (m_fsm == 0 && dmd_valid) acc = 1;
            if (rv == 1 && rd == 0 && rdy) begin q_due.push_back(cyc + LAT); q_line.push_back(rl); end
            model_step(rdy);
            @(negedge clk);
        end
        check("R7 no request past the page end", cross_cnt, 0);
        check("R2 demand forwarded after ready stall", saw_6000, 1);
        check("R6 R9 total hits", dut_hits, mdl_hits);
        summary();
        $finish;
    end
endmodule